// File: doc/BRIEF.md
# Clock-Enable Power State Tracker

This block follows the clock-enable power state of a graphics DRAM device model. It samples the clock-enable input, a decoded-command strobe with its command kind, and a vector that marks which banks are open. From these it reports whether the device is active, in power-down with every bank closed, in power-down with a bank open, or in self refresh. The surrounding model uses the reported state to gate its command inputs and its clock receivers.

Power-down is entered at a rising clock edge that sees clock-enable low. The bank vector picks which kind of power-down is entered. A refresh command during the all-banks-closed power-down moves the device into self refresh. The same command during the bank-open power-down is illegal and is flagged. A normal power-down is left at the first rising edge that sees clock-enable high. The clock receivers come back from self refresh as soon as clock-enable rises, with no clock edge needed. The state register leaves self refresh only after that level has passed through a two-flop synchronizer. A second sticky flag marks clock-enable dropping while a data burst is still running.

Top module: `cke_power_tracker`

## Requirements
- R1: While `rst_n` is low at a rising edge, the tracker resets synchronously. After that edge `pstate` is 0 (active), `rx_en` and `clk_rx_en` are 1, and both violation flags are 0.
- R2: In the active state (code 0), a rising edge that sees `cke` low with `bank_open` all zero moves `pstate` to 1 (precharge power-down) after that edge. In that state `rx_en` is 0 and `clk_rx_en` stays 1.
- R3: In the active state, a rising edge that sees `cke` low with any bit of `bank_open` set moves `pstate` to 2 (active power-down) after that edge. In that state `rx_en` is 0 and `clk_rx_en` is 1.
- R4: From state 1 or 2, `pstate` returns to 0 only at a rising edge that sees `cke` high. Raising `cke` between edges leaves `pstate` and `rx_en` unchanged until that edge.
- R5: In state 1, a rising edge that sees `cke` low and `cmd_valid` high with `cmd_kind` 0 (refresh) moves `pstate` to 3 (self refresh). While in state 3 with `cke` low, `clk_rx_en` and `rx_en` are 0. State 3 is reached from no state other than 1.
- R6: In state 2, a refresh command (`cmd_kind` 0) at an edge with `cke` low sets `viol_sref`, and `pstate` stays 2.
- R7: In state 3, `clk_rx_en` follows a rise of `cke` at once, with no clock edge. `pstate` stays 3 through the first two rising edges after the rise and becomes 0 after the third.
- R8: In state 0 with `cke` high, a command with `cmd_kind` 1 (read), 2 (write) or 3 (snoop) starts a burst. The burst covers the next BURST_LEN rising edges. `cke` low at any of those edges sets `viol_burst`. `cke` low at a later edge does not set it.
- R9: Both violation flags stay set until a rising edge that sees `viol_clr` high clears them. If a new violation happens at that same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable level from the controller |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_kind | input | 2 | 0 refresh, 1 read, 2 write, 3 snoop |
| bank_open | input | NBANK | One bit per bank, 1 = bank open |
| viol_clr | input | 1 | Clears both violation flags |
| pstate | output | 2 | 0 active, 1 precharge power-down, 2 active power-down, 3 self refresh |
| rx_en | output | 1 | Enable for command and data input receivers |
| clk_rx_en | output | 1 | Enable for clock receivers |
| viol_burst | output | 1 | Sticky: clock-enable dropped during a burst |
| viol_sref | output | 1 | Sticky: refresh issued in active power-down |

## Verification
On every cycle, the assertions check the clocked state moves. They check the power-down entry and its split by bank state, the clocked power-down exit, and that self refresh is entered only from precharge power-down. They also check that self refresh holds while clock-enable stays low, that a refresh in active power-down raises its flag, that a burst drop raises its flag, and that the flags are sticky. Some behaviour only the bench scenarios can show. These are the asynchronous rise of the clock-receiver enable, the three-edge delay out of self refresh, and a sweep over every bank-vector pattern. The bench also moves the clock-enable drop across a window around the burst end, to find the exact edge after which no violation is raised.

// File: rtl/cke_power_tracker.sv
module cke_power_tracker #(
  parameter int NBANK     = 8,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [NBANK-1:0] bank_open,
  input  logic             viol_clr,
  output logic [1:0]       pstate,
  output logic             rx_en,
  output logic             clk_rx_en,
  output logic             viol_burst,
  output logic             viol_sref
);
  localparam int CW = $clog2(BURST_LEN + 1);
  localparam logic [1:0] ST_ACT = 2'd0;
  localparam logic [1:0] ST_PPD = 2'd1;
  localparam logic [1:0] ST_APD = 2'd2;
  localparam logic [1:0] ST_SRF = 2'd3;

  logic [1:0]    st;
  logic          sync1, sync2;
  logic [CW-1:0] bcnt;

  wire is_ref     = cmd_valid && (cmd_kind == 2'd0);
  wire busy       = (bcnt != '0);
  wire burst_go   = (st == ST_ACT) && cke && cmd_valid && (cmd_kind != 2'd0);
  wire any_open   = |bank_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_ACT;
      sync1      <= 1'b0;
      sync2      <= 1'b0;
      bcnt       <= '0;
      viol_burst <= 1'b0;
      viol_sref  <= 1'b0;
    end else begin
      sync1 <= cke;
      sync2 <= sync1;
      case (st)
        ST_ACT: if (!cke) st <= any_open ? ST_APD : ST_PPD;
        ST_PPD: if (cke) st <= ST_ACT;
                else if (is_ref) st <= ST_SRF;
        ST_APD: if (cke) st <= ST_ACT;
        default: if (sync2) st <= ST_ACT;
      endcase
      if (burst_go)  bcnt <= CW'(BURST_LEN);
      else if (busy) bcnt <= bcnt - 1'b1;
      viol_burst <= (!cke && busy) || (viol_burst && !viol_clr);
      viol_sref  <= ((st == ST_APD) && !cke && is_ref) || (viol_sref && !viol_clr);
    end
  end

  assign pstate    = st;
  assign rx_en     = (st == ST_ACT);
  assign clk_rx_en = (st != ST_SRF) || cke;
endmodule

module cke_power_tracker_chk #(
  parameter int NBANK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cmd_valid,
  input logic [1:0]       cmd_kind,
  input logic [NBANK-1:0] bank_open,
  input logic             viol_clr,
  input logic [1:0]       pstate,
  input logic             viol_burst,
  input logic             viol_sref
);
  assert_pd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd0 && !cke) |=> (pstate == 2'd1 || pstate == 2'd2));

  assert_apd_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd0 && !cke && (|bank_open)) |=> (pstate == 2'd2));

  assert_pd_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pstate == 2'd1 || pstate == 2'd2) && cke) |=> (pstate == 2'd0));

  assert_sref_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate != 2'd3) |=> (pstate != 2'd3 || $past(pstate) == 2'd1));

  assert_apd_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd2 && !cke && cmd_valid && cmd_kind == 2'd0) |=> (viol_sref && pstate == 2'd2));

  assert_sref_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd3 && !cke && !$past(cke) && !$past(cke, 2)) |=> (pstate == 2'd3));

  assert_burst_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd0 && cke && cmd_valid && cmd_kind != 2'd0) ##1 !cke |=> viol_burst);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_burst && !viol_clr) |=> viol_burst);
endmodule

bind cke_power_tracker cke_power_tracker_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .bank_open(bank_open), .viol_clr(viol_clr), .pstate(pstate),
  .viol_burst(viol_burst), .viol_sref(viol_sref)
);

// File: tb/cke_power_tracker_bench.sv
module cke_power_tracker_bench;
  localparam int NBANK = 8;
  localparam int BL    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [NBANK-1:0] bank_open = '0;
  logic viol_clr = 1'b0;
  logic [1:0] pstate;
  logic rx_en, clk_rx_en, viol_burst, viol_sref;

  int total = 0;
  int bad = 0;

  cke_power_tracker #(.NBANK(NBANK), .BURST_LEN(BL)) u_cke_power_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .bank_open(bank_open), .viol_clr(viol_clr), .pstate(pstate), .rx_en(rx_en),
    .clk_rx_en(clk_rx_en), .viol_burst(viol_burst), .viol_sref(viol_sref)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    viol_clr = 1'b1;
    tick();
    viol_clr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick();
    tick();
    chk("R1 pstate", pstate, 0);
    chk("R1 rx_en", rx_en, 1);
    chk("R1 clk_rx_en", clk_rx_en, 1);
    chk("R1 flags", {viol_burst, viol_sref}, 0);
    rst_n = 1'b1;
    tick();

    for (int p = 0; p < (1 << NBANK); p++) begin
      bank_open = p[NBANK-1:0];
      cke = 1'b0;
      tick();
      chk(p == 0 ? "R2 state" : "R3 state", pstate, (p == 0) ? 1 : 2);
      chk("R2 R3 rx_en", rx_en, 0);
      chk("R2 R3 clk_rx_en", clk_rx_en, 1);
      cke = 1'b1;
      #1;
      chk("R4 no early exit", pstate, (p == 0) ? 1 : 2);
      tick();
      chk("R4 exit", pstate, 0);
      chk("R4 rx_en", rx_en, 1);
    end

    bank_open = '0;
    cke = 1'b0;
    tick();
    cmd_valid = 1'b1;
    cmd_kind = 2'd0;
    tick();
    cmd_valid = 1'b0;
    chk("R5 enter sref", pstate, 3);
    chk("R5 clk_rx_en", clk_rx_en, 0);
    chk("R5 rx_en", rx_en, 0);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R7 hold", pstate, 3);
    end
    #1;
    cke = 1'b1;
    #1;
    chk("R7 async clk_rx_en", clk_rx_en, 1);
    chk("R7 still sref", pstate, 3);
    tick();
    chk("R7 edge1", pstate, 3);
    tick();
    chk("R7 edge2", pstate, 3);
    tick();
    chk("R7 edge3", pstate, 0);
    chk("R5 R6 no flag", viol_sref, 0);

    bank_open = 8'h10;
    cke = 1'b0;
    tick();
    chk("R6 apd", pstate, 2);
    cmd_valid = 1'b1;
    cmd_kind = 2'd0;
    tick();
    cmd_valid = 1'b0;
    chk("R6 flag", viol_sref, 1);
    chk("R6 stays apd", pstate, 2);
    tick();
    tick();
    chk("R9 sticky", viol_sref, 1);
    viol_clr = 1'b1;
    cmd_valid = 1'b1;
    tick();
    chk("R9 set wins", viol_sref, 1);
    cmd_valid = 1'b0;
    tick();
    viol_clr = 1'b0;
    chk("R9 cleared", viol_sref, 0);
    cke = 1'b1;
    tick();
    chk("R4 back", pstate, 0);
    bank_open = '0;

    for (int k = 1; k < 4; k++) begin
      for (int off = 1; off <= BL + 2; off++) begin
        cmd_valid = 1'b1;
        cmd_kind = k[1:0];
        tick();
        cmd_valid = 1'b0;
        for (int j = 1; j < off; j++) tick();
        cke = 1'b0;
        tick();
        chk("R8 burst drop", viol_burst, (off <= BL) ? 1 : 0);
        cke = 1'b1;
        tick();
        tick();
        chk("R9 burst sticky", viol_burst, (off <= BL) ? 1 : 0);
        clear_flags();
        chk("R9 burst clear", viol_burst, 0);
        for (int j = 0; j < BL; j++) tick();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule